// File: doc/BRIEF.md
# Snooping Write-Invalidate Line Coherence Controller

This block is the coherence logic that sits beside one private write-back cache in a small shared-bus multiprocessor. It keeps a three-state tag (Invalid, Shared, Modified) for each line of a small direct-mapped store, serves its own processor's loads, stores and evictions, and watches every transaction that other caches place on the shared bus. A store first wins the bus and broadcasts an invalidate, so at any moment a line has either one writer or any number of readers. A cache that holds a line dirty answers a remote read by supplying the data and writing it back.

The processor holds a request until it sees an acknowledge pulse. A load or store that cannot complete locally raises a bus request and waits for the grant from an external arbiter, which stalls the processor meanwhile. Remote transactions arrive on the snoop inputs. Modified data leaves through a one-word memory write port, either on eviction or when another cache reads the line.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After reset every line is Invalid, and `bus_req`, `cpu_ack`, `mem_wr` and `snp_dirty` are low. The first load of any address therefore goes to the bus.
- R2: A load that misses raises `bus_req` with `bus_cmd` = 2'b01 (read) and `bus_addr` = the request address, and holds them unchanged until `bus_gnt`. In the first cycle with `bus_rvalid` after the grant, it acknowledges with `cpu_rdata` = `bus_rdata` and leaves the line Shared.
- R3: A load that hits a Shared or Modified line, and a store that hits a Modified line, acknowledge in the same cycle as the request and use neither the bus nor the memory port. The line index is the low log2(LINES) address bits and the tag is the rest.
- R4: A store to a Shared line or to a missing line raises `bus_req` with `bus_cmd` = 2'b10 (invalidate). In the grant cycle it writes the word, makes the line Modified and acknowledges.
- R5: A snooped read (`snp_cmd` = 2'b01) that hits a Modified line raises `snp_dirty` and puts the line data on `snp_data` in the same cycle. In that cycle it also writes the line to memory and then leaves the line Shared, so a later local store must invalidate again.
- R6: A snooped read that hits a Shared line, or hits no line, leaves `snp_dirty` and `mem_wr` low.
- R7: A snooped invalidate (`snp_cmd` = 2'b10) that hits a line makes it Invalid, so the next local load goes to the bus. An invalidate for another tag at the same index has no effect.
- R8: An eviction (`cpu_op` = 2'b10) of a Modified line writes it to memory in the cycle after the request and acknowledges in that cycle. An eviction of a Shared line acknowledges at once without a memory write. Either way the line becomes Invalid.
- R9: A load or store that misses where the index holds a Modified line of another tag writes that victim to memory before it raises `bus_req`.
- R10: When a snooped transaction hits the line a local request addresses in the same cycle, the snoop takes effect first and the local request waits. A store that hits a Modified line while a remote read hits that line therefore gives the old data to the snoop, and the store then completes through an invalidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until acknowledged |
| cpu_op | input | 2 | 00 load, 01 store, 10 evict |
| cpu_addr | input | ADDR_W | Request word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ack | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_ack |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_cmd | output | 2 | Own bus command: 01 read, 10 invalidate |
| bus_addr | output | ADDR_W | Own bus address |
| bus_rvalid | input | 1 | Fill data valid for an own read |
| bus_rdata | input | DATA_W | Fill data from memory or a dirty owner |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command: 01 read, 10 invalidate |
| snp_addr | input | ADDR_W | Snooped address |
| snp_dirty | output | 1 | This cache supplies dirty data |
| snp_data | output | DATA_W | Supplied data |
| mem_wr | output | 1 | Memory write-back strobe |
| mem_addr | output | ADDR_W | Write-back address |
| mem_wdata | output | DATA_W | Write-back data |

## Verification
A snoop and the block's own processor request can address the same line in the same cycle. The bench provokes this by presenting a store that hits a Modified line in the cycle a remote read for that line arrives. It judges the outcome by three things: the snoop gets the old data with `snp_dirty` and a write-back, the store is not acknowledged in that cycle, and the store later completes through an invalidate on the bus. The random phase mixes loads, stores, evictions, remote reads and remote writes over sixteen addresses and compares every returned and written-back value with the last value written anywhere.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {LS_INV = 2'b00, LS_SHR = 2'b01, LS_MOD = 2'b10} line_st_e;
  typedef enum logic [1:0] {BC_NONE = 2'b00, BC_READ = 2'b01, BC_INVAL = 2'b10} bus_cmd_e;
  typedef enum logic [1:0] {OP_LOAD = 2'b00, OP_STORE = 2'b01, OP_EVICT = 2'b10} cpu_op_e;
  typedef enum logic [1:0] {FS_IDLE, FS_WBACK, FS_ARB, FS_FILL} fsm_e;
endpackage

// File: rtl/coh_line_array.sv
module coh_line_array
  import coh_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             sn_en,
  input  logic [IDX_W-1:0]                 sn_idx,
  input  line_st_e                         sn_st,
  input  logic                             lc_en,
  input  logic [IDX_W-1:0]                 lc_idx,
  input  line_st_e                         lc_st,
  input  logic [TAG_W-1:0]                 lc_tag,
  input  logic                             lc_dat_en,
  input  logic [DATA_W-1:0]                lc_dat,
  output line_st_e [LINES-1:0]             st_q,
  output logic [LINES-1:0][TAG_W-1:0]      tag_q,
  output logic [LINES-1:0][DATA_W-1:0]     dat_q
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_e          st_r;
    logic [TAG_W-1:0]  tag_r;
    logic [DATA_W-1:0] dat_r;
    logic              sn_sel, lc_sel;

    assign sn_sel = sn_en && (sn_idx == IDX_W'(g));
    assign lc_sel = lc_en && (lc_idx == IDX_W'(g)) && !sn_sel;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      st_r <= LS_INV;
      else if (sn_sel) st_r <= sn_st;
      else if (lc_sel) st_r <= lc_st;
    end

    always_ff @(posedge clk) begin
      if (lc_sel)              tag_r <= lc_tag;
      if (lc_sel && lc_dat_en) dat_r <= lc_dat;
    end

    assign st_q[g]  = st_r;
    assign tag_q[g] = tag_r;
    assign dat_q[g] = dat_r;
  end
endmodule

// File: rtl/coh_snoop.sv
module coh_snoop
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LINES  = 4,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic                         snp_valid,
  input  logic [1:0]                   snp_cmd,
  input  logic [ADDR_W-1:0]            snp_addr,
  input  line_st_e [LINES-1:0]         st_q,
  input  logic [LINES-1:0][TAG_W-1:0]  tag_q,
  input  logic [LINES-1:0][DATA_W-1:0] dat_q,
  output logic                         sn_hit,
  output logic [IDX_W-1:0]             sn_idx,
  output logic                         sn_upd,
  output line_st_e                     sn_new_st,
  output logic                         sn_wb,
  output logic [DATA_W-1:0]            sn_data
);
  logic [TAG_W-1:0] s_tag;

  always_comb begin
    sn_idx    = snp_addr[IDX_W-1:0];
    s_tag     = snp_addr[ADDR_W-1:IDX_W];
    sn_hit    = snp_valid && (st_q[sn_idx] != LS_INV) && (tag_q[sn_idx] == s_tag);
    sn_data   = dat_q[sn_idx];
    sn_upd    = 1'b0;
    sn_wb     = 1'b0;
    sn_new_st = st_q[sn_idx];
    if (sn_hit && snp_cmd == BC_READ && st_q[sn_idx] == LS_MOD) begin
      sn_wb     = 1'b1;
      sn_upd    = 1'b1;
      sn_new_st = LS_SHR;
    end else if (sn_hit && snp_cmd == BC_INVAL) begin
      sn_upd    = 1'b1;
      sn_new_st = LS_INV;
    end
  end
endmodule

// File: rtl/coh_req_fsm.sv
module coh_req_fsm
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LINES  = 4,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cpu_req,
  input  logic [1:0]                   cpu_op,
  input  logic [ADDR_W-1:0]            cpu_addr,
  input  logic [DATA_W-1:0]            cpu_wdata,
  output logic                         cpu_ack,
  output logic [DATA_W-1:0]            cpu_rdata,
  input  line_st_e [LINES-1:0]         st_q,
  input  logic [LINES-1:0][TAG_W-1:0]  tag_q,
  input  logic [LINES-1:0][DATA_W-1:0] dat_q,
  input  logic                         snp_blk,
  input  logic                         mem_busy,
  output logic                         bus_req,
  input  logic                         bus_gnt,
  output logic [1:0]                   bus_cmd,
  output logic [ADDR_W-1:0]            bus_addr,
  input  logic                         bus_rvalid,
  input  logic [DATA_W-1:0]            bus_rdata,
  output logic                         wb_go,
  output logic [ADDR_W-1:0]            wb_addr,
  output logic [DATA_W-1:0]            wb_data,
  output logic                         lc_en,
  output logic [IDX_W-1:0]             lc_idx,
  output line_st_e                     lc_st,
  output logic [TAG_W-1:0]             lc_tag,
  output logic                         lc_dat_en,
  output logic [DATA_W-1:0]            lc_dat
);
  fsm_e             fs_q, fs_d;
  logic [TAG_W-1:0] rq_tag;
  line_st_e         cur_st;
  logic             hit, vic_mod, wb_done;

  always_comb begin
    lc_idx    = cpu_addr[IDX_W-1:0];
    rq_tag    = cpu_addr[ADDR_W-1:IDX_W];
    cur_st    = st_q[lc_idx];
    hit       = (cur_st != LS_INV) && (tag_q[lc_idx] == rq_tag);
    vic_mod   = (cur_st == LS_MOD) && (tag_q[lc_idx] != rq_tag);
    fs_d      = fs_q;
    cpu_ack   = 1'b0;
    cpu_rdata = dat_q[lc_idx];
    bus_req   = 1'b0;
    bus_cmd   = (cpu_op == OP_STORE) ? BC_INVAL : BC_READ;
    bus_addr  = cpu_addr;
    wb_go     = 1'b0;
    wb_addr   = {tag_q[lc_idx], lc_idx};
    wb_data   = dat_q[lc_idx];
    lc_en     = 1'b0;
    lc_st     = LS_INV;
    lc_tag    = rq_tag;
    lc_dat_en = 1'b0;
    lc_dat    = cpu_wdata;
    wb_done   = 1'b0;
    unique case (fs_q)
      FS_IDLE: if (cpu_req && !snp_blk) begin
        case (cpu_op)
          OP_LOAD:
            if (hit)          cpu_ack = 1'b1;
            else if (vic_mod) fs_d = FS_WBACK;
            else              fs_d = FS_ARB;
          OP_STORE:
            if (hit && cur_st == LS_MOD) begin
              lc_en = 1'b1; lc_st = LS_MOD; lc_dat_en = 1'b1; cpu_ack = 1'b1;
            end else if (!hit && vic_mod) fs_d = FS_WBACK;
            else fs_d = FS_ARB;
          OP_EVICT:
            if (hit && cur_st == LS_MOD) fs_d = FS_WBACK;
            else begin
              lc_en   = hit;
              lc_tag  = tag_q[lc_idx];
              cpu_ack = 1'b1;
            end
          default: cpu_ack = 1'b1;
        endcase
      end
      FS_WBACK: if (!snp_blk) begin
        lc_tag = tag_q[lc_idx];
        if (cur_st == LS_MOD) begin
          if (!mem_busy) begin
            wb_go = 1'b1; lc_en = 1'b1; wb_done = 1'b1;
          end
        end else begin
          lc_en = 1'b1; wb_done = 1'b1;
        end
        if (wb_done) begin
          if (cpu_op == OP_EVICT) begin
            cpu_ack = 1'b1; fs_d = FS_IDLE;
          end else fs_d = FS_ARB;
        end
      end
      FS_ARB: begin
        bus_req = 1'b1;
        if (bus_gnt) begin
          if (cpu_op == OP_STORE) begin
            lc_en = 1'b1; lc_st = LS_MOD; lc_dat_en = 1'b1; cpu_ack = 1'b1;
            fs_d  = FS_IDLE;
          end else fs_d = FS_FILL;
        end
      end
      FS_FILL: if (bus_rvalid) begin
        lc_en = 1'b1; lc_st = LS_SHR; lc_dat_en = 1'b1; lc_dat = bus_rdata;
        cpu_rdata = bus_rdata; cpu_ack = 1'b1; fs_d = FS_IDLE;
      end
      default: fs_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fs_q <= FS_IDLE;
    else        fs_q <= fs_d;
  end
endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LINES  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic [1:0]        cpu_op,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ack,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rvalid,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_dirty,
  output logic [DATA_W-1:0] snp_data,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [1:0]                   rst_pipe;
  logic                         rst_n_s;
  line_st_e [LINES-1:0]         st_q;
  logic [LINES-1:0][TAG_W-1:0]  tag_q;
  logic [LINES-1:0][DATA_W-1:0] dat_q;
  logic                         sn_hit, sn_upd, sn_wb;
  logic [IDX_W-1:0]             sn_idx, lc_idx;
  line_st_e                     sn_new_st, lc_st;
  logic                         lc_en, lc_dat_en, wb_go, snp_blk;
  logic [TAG_W-1:0]             lc_tag;
  logic [DATA_W-1:0]            lc_dat, wb_data;
  logic [ADDR_W-1:0]            wb_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  coh_line_array #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
    .clk(clk), .rst_n(rst_n_s),
    .sn_en(sn_upd), .sn_idx(sn_idx), .sn_st(sn_new_st),
    .lc_en(lc_en), .lc_idx(lc_idx), .lc_st(lc_st), .lc_tag(lc_tag),
    .lc_dat_en(lc_dat_en), .lc_dat(lc_dat),
    .st_q(st_q), .tag_q(tag_q), .dat_q(dat_q)
  );

  coh_snoop #(.ADDR_W(ADDR_W), .LINES(LINES), .DATA_W(DATA_W)) u_snoop (
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .st_q(st_q), .tag_q(tag_q), .dat_q(dat_q),
    .sn_hit(sn_hit), .sn_idx(sn_idx), .sn_upd(sn_upd), .sn_new_st(sn_new_st),
    .sn_wb(sn_wb), .sn_data(snp_data)
  );

  assign snp_blk = sn_hit && (sn_idx == cpu_addr[IDX_W-1:0]);

  coh_req_fsm #(.ADDR_W(ADDR_W), .LINES(LINES), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n_s),
    .cpu_req(cpu_req), .cpu_op(cpu_op), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .st_q(st_q), .tag_q(tag_q), .dat_q(dat_q),
    .snp_blk(snp_blk), .mem_busy(sn_wb),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .wb_go(wb_go), .wb_addr(wb_addr), .wb_data(wb_data),
    .lc_en(lc_en), .lc_idx(lc_idx), .lc_st(lc_st), .lc_tag(lc_tag),
    .lc_dat_en(lc_dat_en), .lc_dat(lc_dat)
  );

  assign snp_dirty = sn_wb;
  assign mem_wr    = sn_wb | wb_go;
  assign mem_addr  = sn_wb ? snp_addr : wb_addr;
  assign mem_wdata = sn_wb ? snp_data : wb_data;
endmodule

// File: rtl/coh_chk.sv
module coh_chk
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LINES  = 4,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input logic                        clk,
  input logic                        rst_n_s,
  input logic                        cpu_ack,
  input logic [1:0]                  cpu_op,
  input logic [ADDR_W-1:0]           cpu_addr,
  input logic                        bus_req,
  input logic                        bus_gnt,
  input logic [1:0]                  bus_cmd,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic                        snp_valid,
  input logic [1:0]                  snp_cmd,
  input logic [ADDR_W-1:0]           snp_addr,
  input logic                        snp_dirty,
  input logic [DATA_W-1:0]           snp_data,
  input logic                        mem_wr,
  input logic [ADDR_W-1:0]           mem_addr,
  input logic [DATA_W-1:0]           mem_wdata,
  input line_st_e [LINES-1:0]        st_q,
  input logic [LINES-1:0][TAG_W-1:0] tag_q
);
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_addr) && $stable(bus_cmd));

  assert_store_owns_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    cpu_ack && cpu_op == OP_STORE |=> st_q[$past(cpu_addr[IDX_W-1:0])] == LS_MOD);

  assert_dirty_writeback_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    snp_dirty |-> mem_wr && mem_addr == snp_addr && mem_wdata == snp_data);

  assert_supplier_shares_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    snp_dirty |=> st_q[$past(snp_addr[IDX_W-1:0])] == LS_SHR);

  assert_dirty_on_read_only_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    snp_dirty |-> snp_valid && snp_cmd == BC_READ);

  assert_inval_drops_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    snp_valid && snp_cmd == BC_INVAL |=>
      !(st_q[$past(snp_addr[IDX_W-1:0])] != LS_INV &&
        tag_q[$past(snp_addr[IDX_W-1:0])] == $past(snp_addr[ADDR_W-1:IDX_W])));
endmodule

bind snoop_coh_ctrl coh_chk #(.ADDR_W(ADDR_W), .LINES(LINES), .DATA_W(DATA_W)) u_coh_chk (
  .clk(clk), .rst_n_s(rst_n_s), .cpu_ack(cpu_ack), .cpu_op(cpu_op), .cpu_addr(cpu_addr),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
  .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
  .snp_dirty(snp_dirty), .snp_data(snp_data),
  .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .st_q(st_q), .tag_q(tag_q)
);

// File: tb/tb_snoop_coh_ctrl.sv
module tb_snoop_coh_ctrl;
  logic        clk, rst_n;
  logic        cpu_req;
  logic [1:0]  cpu_op;
  logic [7:0]  cpu_addr;
  logic [15:0] cpu_wdata;
  logic        cpu_ack;
  logic [15:0] cpu_rdata;
  logic        bus_req, bus_gnt;
  logic [1:0]  bus_cmd;
  logic [7:0]  bus_addr;
  logic        bus_rvalid;
  logic [15:0] bus_rdata;
  logic        snp_valid;
  logic [1:0]  snp_cmd;
  logic [7:0]  snp_addr;
  logic        snp_dirty;
  logic [15:0] snp_data;
  logic        mem_wr;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata;

  snoop_coh_ctrl dut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int nchk = 0, nfail = 0;
  logic [15:0] golden [16];
  int m_st [4];
  int m_tag [4];

  logic [15:0] r_rd, r_wbd, s_data, s_mdata;
  logic [7:0]  r_wba, s_maddr;
  logic [1:0]  r_cmd;
  int          r_cyc, r_nwb, r_wb_at, r_req_at;
  bit          r_used, s_dirty, s_mwr;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    nchk++; nfail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  function automatic bit m_hit(input int a);
    return m_st[a % 4] != 0 && m_tag[a % 4] == a / 4;
  endfunction

  // Entered at a negedge with the request already driven; leaves at a negedge with it dropped.
  task automatic service(input int a);
    bit granted = 0, grd = 0, filled = 0, done = 0, pr;
    logic [1:0] pc;
    int wc = -1;
    r_cyc = 0; r_nwb = 0; r_used = 0; r_cmd = 0; r_wb_at = -1; r_req_at = -1;
    while (!done) begin
      #1;
      if (mem_wr) begin
        r_nwb++; r_wba = mem_addr; r_wbd = mem_wdata;
        if (r_wb_at < 0) r_wb_at = r_cyc;
      end
      if (bus_req) begin
        r_used = 1; r_cmd = bus_cmd;
        if (r_req_at < 0) r_req_at = r_cyc;
      end
      pr = bus_req; pc = bus_cmd;
      if (cpu_ack) begin r_rd = cpu_rdata; done = 1; end
      @(negedge clk);
      bus_gnt = 0; bus_rvalid = 0;
      if (done) cpu_req = 0;
      else begin
        r_cyc++;
        if (r_cyc > 60) begin
          chk("R2 request never acknowledged", 0, 1);
          done = 1; cpu_req = 0;
        end else if (pr && !granted) begin
          if (wc < 0) wc = $urandom % 3;
          if (wc == 0) begin bus_gnt = 1; granted = 1; grd = (pc == 2'b01); end
          else wc--;
        end else if (grd && !filled) begin
          bus_rvalid = 1; bus_rdata = golden[a]; filled = 1;
        end
      end
    end
  endtask

  task automatic issue(input logic [1:0] op, input int a, input logic [15:0] v);
    cpu_req = 1; cpu_op = op; cpu_addr = 8'(a); cpu_wdata = v;
    service(a);
  endtask

  task automatic check_victim(input bit vm, input int vic);
    chk("R9 victim write-back count", r_nwb, vm);
    if (vm) begin
      chk("R9 victim address", r_wba, vic);
      chk("R9 victim data", r_wbd, golden[vic]);
      chk("R9 write-back before bus request", r_wb_at < r_req_at, 1);
    end
  endtask

  task automatic do_load(input int a);
    int i = a % 4;
    bit miss = !m_hit(a);
    bit vm = miss && m_st[i] == 2;
    int vic = m_tag[i] * 4 + i;
    issue(2'b00, a, 16'h0);
    chk("R3 load uses bus only on miss", r_used, miss);
    if (miss) chk("R2 load miss command", r_cmd, 2'b01);
    chk("R2 load data", r_rd, golden[a]);
    check_victim(vm, vic);
    m_st[i] = (miss || m_st[i] == 0) ? 1 : m_st[i];
    m_tag[i] = a / 4;
  endtask

  task automatic do_store(input int a, input logic [15:0] v);
    int i = a % 4;
    bit hm = m_hit(a) && m_st[i] == 2;
    bit vm = !m_hit(a) && m_st[i] == 2;
    int vic = m_tag[i] * 4 + i;
    issue(2'b01, a, v);
    chk("R4 store uses bus unless Modified hit", r_used, !hm);
    if (!hm) chk("R4 store bus command", r_cmd, 2'b10);
    check_victim(vm, vic);
    golden[a] = v; m_st[i] = 2; m_tag[i] = a / 4;
  endtask

  task automatic do_evict(input int a);
    int i = a % 4;
    bit h = m_hit(a);
    bit hm = h && m_st[i] == 2;
    issue(2'b10, a, 16'h0);
    chk("R8 evict write-back count", r_nwb, hm);
    if (hm) begin
      chk("R8 evict address", r_wba, a);
      chk("R8 evict data", r_wbd, golden[a]);
    end
    chk("R8 evict never uses bus", r_used, 0);
    if (h) m_st[i] = 0;
  endtask

  task automatic do_snoop(input logic [1:0] cmd, input int a, input logic [15:0] nv);
    int i = a % 4;
    bit h = m_hit(a);
    bit ed = (cmd == 2'b01) && h && m_st[i] == 2;
    snp_valid = 1; snp_cmd = cmd; snp_addr = 8'(a);
    #1;
    s_dirty = snp_dirty; s_data = snp_data; s_mwr = mem_wr; s_maddr = mem_addr; s_mdata = mem_wdata;
    chk(cmd == 2'b01 ? "R5 R6 snoop dirty response" : "R7 invalidate gives no response", s_dirty, ed);
    chk("R6 snoop memory write only when dirty", s_mwr, ed);
    if (ed) begin
      chk("R5 supplied data", s_data, golden[a]);
      chk("R5 write-back address", s_maddr, a);
    end
    @(negedge clk);
    snp_valid = 0;
    if (ed) m_st[i] = 1;
    if (cmd == 2'b10) begin
      if (h) m_st[i] = 0;
      golden[a] = nv;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; cpu_req = 0; cpu_op = 0; cpu_addr = 0; cpu_wdata = 0;
    bus_gnt = 0; bus_rvalid = 0; bus_rdata = 0; snp_valid = 0; snp_cmd = 0; snp_addr = 0;
    for (int k = 0; k < 16; k++) golden[k] = 16'h1000 + 16'(k);
    for (int k = 0; k < 4; k++) begin m_st[k] = 0; m_tag[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 bus_req after reset", bus_req, 0);
    chk("R1 cpu_ack after reset", cpu_ack, 0);
    chk("R1 mem_wr after reset", mem_wr, 0);
    chk("R1 snp_dirty after reset", snp_dirty, 0);
    @(negedge clk);

    // R1 R2: first load misses
    do_load(5);
    chk("R1 first load goes to bus", r_used, 1);
    // R3: hit completes in the request cycle
    do_load(5);
    chk("R3 load hit latency", r_cyc, 0);
    // R4 then R3 store hit on Modified
    do_store(5, 16'hA5A5);
    do_store(5, 16'hB6B6);
    chk("R3 store hit latency", r_cyc, 0);
    // R5: remote read of the dirty line
    do_snoop(2'b01, 5, 16'h0);
    chk("R5 dirty supply seen", s_dirty, 1);
    chk("R5 supplied value", s_data, 16'hB6B6);
    do_store(5, 16'hC7C7);
    chk("R5 store after supply needs invalidate", r_cmd, 2'b10);
    // R6: remote read of a line not held
    do_snoop(2'b01, 1, 16'h0);
    chk("R6 no response for absent line", s_dirty, 0);
    // R7: invalidate for other tag is ignored, matching tag drops line
    do_snoop(2'b10, 9, 16'h2009);
    do_load(5);
    chk("R7 other-tag invalidate keeps line", r_used, 0);
    do_snoop(2'b10, 5, 16'h3005);
    do_load(5);
    chk("R7 invalidated line misses", r_used, 1);
    chk("R7 fresh value fetched", r_rd, 16'h3005);
    // R8: evict Modified then Shared
    do_store(6, 16'hD8D8);
    do_evict(6);
    chk("R8 Modified evict latency", r_cyc, 1);
    chk("R8 Modified evict wrote", r_nwb, 1);
    do_load(6);
    do_evict(6);
    chk("R8 Shared evict latency", r_cyc, 0);
    chk("R8 Shared evict silent", r_nwb, 0);
    do_load(6);
    chk("R8 evicted line misses", r_used, 1);
    // R9: victim write-back ahead of the fill
    do_store(3, 16'hE9E9);
    do_load(7);
    chk("R9 victim written", r_nwb, 1);
    chk("R9 victim address", r_wba, 3);
    // R10: same-line snoop and store in one cycle
    do_store(12, 16'hF1F1);
    cpu_req = 1; cpu_op = 2'b01; cpu_addr = 8'd12; cpu_wdata = 16'h4242;
    snp_valid = 1; snp_cmd = 2'b01; snp_addr = 8'd12;
    #1;
    chk("R10 store stalled by snoop", cpu_ack, 0);
    chk("R10 snoop sees old data", snp_data, 16'hF1F1);
    chk("R10 snoop dirty", snp_dirty, 1);
    @(negedge clk);
    snp_valid = 0;
    service(12);
    chk("R10 store then invalidates", r_cmd, 2'b10);
    chk("R10 store used bus", r_used, 1);
    golden[12] = 16'h4242; m_st[0] = 2; m_tag[0] = 3;
    do_load(12);
    chk("R10 final value", r_rd, 16'h4242);

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      int a = $urandom % 16;
      case ($urandom % 5)
        0: do_load(a);
        1: do_store(a, 16'($urandom));
        2: do_evict(a);
        3: do_snoop(2'b01, a, 16'h0);
        default: do_snoop(2'b10, a, 16'($urandom));
      endcase
    end
    for (int a = 0; a < 16; a++) do_load(a);
    finish_up();
  end
endmodule